// File: doc/BRIEF.md
# Silence Flag Generator

This block watches a stereo sample stream at the frame rate and raises a single silence flag when the output may be muted externally. Each frame is marked by a one-cycle strobe that comes with the left and right samples. The block also sees the soft-mute request. Its single output is a registered flag that can drive an external analog mute switch.

There are two independent triggers. The first is a run of frames in which both channels carry exactly zero. The second is a soft-mute request that has been held long enough to cover the full attenuation ramp plus the zero window. The flag is the OR of the two. It drops on the next clock when the condition that holds it ends: a non-zero sample arrives on either channel, or the mute request is withdrawn. A mute release acts at once, even between frame strobes.

Top module: `silence_flag_gen`

## Requirements
- R1: While `rst` is high, `silence_flag` is 0 on the next clock, and both run lengths restart from zero.
- R2: With `mute_req` low, `silence_flag` goes to 1 on the clock edge that samples the ZERO_RUN-th (default 8192) consecutive strobed frame in which both samples are all-zero. It is still 0 after ZERO_RUN-1 such frames.
- R3: A strobed frame in which either sample is non-zero drives `silence_flag` to 0 on the next clock when the mute trigger is not met. The zero run then starts again from zero, so a full ZERO_RUN further zero frames are needed.
- R4: While `mute_req` stays high, `silence_flag` goes to 1 on the edge that samples the (ZERO_RUN+RAMP_LEN+1)-th strobe (default 9215), whatever the sample values. It is still 0 one strobe earlier.
- R5: When `mute_req` goes low, the mute count clears on the next clock, even without a strobe. `silence_flag` then drops unless the zero trigger is met. A new request counts again from zero.
- R6: `silence_flag` is the OR of the two triggers. When the zero run is complete, raising or lowering `mute_req` leaves the flag at 1.
- R7: Samples and strobe-less clocks do not advance either count. A non-zero sample that is present without `frame_stb` does not change `silence_flag`, and the flag only rises on a clock that samples a strobe.
- R8: Both counts saturate at their thresholds, so `silence_flag` stays 1 for as long as its trigger persists and never wraps back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe, one per frame (word-select period) |
| left_smp | input | SMP_W | Left sample, two's complement, valid with the strobe |
| right_smp | input | SMP_W | Right sample, two's complement, valid with the strobe |
| mute_req | input | 1 | Soft-mute request, level sensitive |
| silence_flag | output | 1 | Registered silence flag |

## Verification
On every cycle, the assertions check the following: counts never pass their saturation limit, a clear empties a count on the next clock, and a count holds still when it is neither cleared nor stepped. They also check that a non-zero strobed frame with no mute request forces the flag low, and that the flag never rises without a strobe. Some behaviours only the scenarios can show. These are the exact frame on which each trigger fires (8192 zero frames, and 9215 strobes of held mute), the restart of a run after an interruption, the OR coupling when one trigger ends while the other holds, and a mute release between strobes.

// File: rtl/silflag_pkg.sv
package silflag_pkg;
  localparam int DEF_SMP_W    = 18;
  localparam int DEF_ZERO_RUN = 8192;
  localparam int DEF_RAMP_LEN = 1022;

  // width able to hold values 0..limit
  function automatic int cnt_width(input int limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/silflag_zero_sense.sv
module silflag_zero_sense #(
  parameter int SMP_W  = 18,
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0][SMP_W-1:0] smp,
  output logic                         all_zero
);
  logic [NUM_CH-1:0] ch_zero;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_zero[c] = (smp[c] == '0);
  end

  assign all_zero = &ch_zero;
endmodule

// File: rtl/silflag_run_ctr.sv
module silflag_run_ctr #(
  parameter int LIMIT = 8192,
  localparam int CW   = silflag_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic          hit_next,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc && (cnt_q != LIM))
      cnt_d = cnt_q + 1'b1;
  end

  assign hit_next = (cnt_d == LIM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R8: count never passes its limit
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);

  // R5 / R3: a clear empties the count on the next clock
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R7: without a clear or a step the count holds
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/silence_flag_gen.sv
module silence_flag_gen #(
  parameter int SMP_W    = silflag_pkg::DEF_SMP_W,
  parameter int ZERO_RUN = silflag_pkg::DEF_ZERO_RUN,
  parameter int RAMP_LEN = silflag_pkg::DEF_RAMP_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  input  logic             mute_req,
  output logic             silence_flag
);
  localparam int MUTE_TRIP = ZERO_RUN + RAMP_LEN + 1;
  localparam int ZCW       = silflag_pkg::cnt_width(ZERO_RUN);
  localparam int MCW       = silflag_pkg::cnt_width(MUTE_TRIP);

  logic           both_zero;
  logic           zero_hit, mute_hit;
  logic [ZCW-1:0] zero_cnt;
  logic [MCW-1:0] mute_cnt;

  silflag_zero_sense #(.SMP_W(SMP_W), .NUM_CH(2)) u_sense (
    .smp      ({right_smp, left_smp}),
    .all_zero (both_zero)
  );

  // zero-run count: steps on all-zero frames, clears on any non-zero frame
  silflag_run_ctr #(.LIMIT(ZERO_RUN)) u_zero_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (frame_stb && !both_zero),
    .inc      (frame_stb && both_zero),
    .hit_next (zero_hit),
    .cnt_q    (zero_cnt)
  );

  // mute-duration count: steps per frame while requested, clears at once on release
  silflag_run_ctr #(.LIMIT(MUTE_TRIP)) u_mute_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (!mute_req),
    .inc      (frame_stb),
    .hit_next (mute_hit),
    .cnt_q    (mute_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) silence_flag <= 1'b0;
    else     silence_flag <= zero_hit | mute_hit;
  end

  // R1: reset forces the flag low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !silence_flag);

  // R3: non-zero frame without a mute request drops the flag
  assert_nonzero_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && ((left_smp != '0) || (right_smp != '0)) && !mute_req)
      |=> !silence_flag);

  // R7: the flag rises only on a strobed clock
  assert_rise_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(silence_flag) |-> $past(frame_stb));

  // R8: counts stay within limits at the top level
  assert_counts_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    (zero_cnt <= ZCW'(ZERO_RUN)) && (mute_cnt <= MCW'(MUTE_TRIP)));
endmodule

// File: tb/silence_flag_gen_tb_top.sv
module silence_flag_gen_tb_top;
  localparam int W  = 18;
  localparam int ZR = 8192;
  localparam int MT = 8192 + 1022 + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_stb = 1'b0;
  logic [W-1:0] left_smp = '0;
  logic [W-1:0] right_smp = '0;
  logic         mute_req = 1'b0;
  logic         silence_flag;

  always #4 clk = ~clk;

  silence_flag_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .frame_stb    (frame_stb),
    .left_smp     (left_smp),
    .right_smp    (right_smp),
    .mute_req     (mute_req),
    .silence_flag (silence_flag)
  );

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  int    zrun   = 0;
  int    mrun   = 0;
  string cur_req = "R1";
  bit    done   = 1'b0;

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: silence_flag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one strobed frame, model computed from the requirements
  task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r, input logic m);
    item_t it;
    @(negedge clk);
    left_smp = l; right_smp = r; mute_req = m; frame_stb = 1'b1;
    if (l == '0 && r == '0) zrun = (zrun < ZR) ? zrun + 1 : ZR;
    else                    zrun = 0;
    if (m) mrun = (mrun < MT) ? mrun + 1 : MT;
    else   mrun = 0;
    it.exp = (zrun >= ZR) || (mrun >= MT);
    it.req = cur_req;
    q.push_back(it);
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic frames(input int n, input logic [W-1:0] l, input logic [W-1:0] r, input logic m);
    for (int i = 0; i < n; i++) frame(l, r, m);
  endtask

  // monitor: pops one expected item per strobe, after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (frame_stb && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(silence_flag, it.exp, it.req);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(silence_flag, 1'b0, "R1");
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #2 check(silence_flag, 1'b0, "R1");

    // R2: exact zero-run threshold
    cur_req = "R2";
    frames(ZR - 1, '0, '0, 1'b0);
    frame('0, '0, 1'b0);
    // R8: saturation keeps it high
    cur_req = "R8";
    frames(20, '0, '0, 1'b0);

    // R7: non-zero sample without strobe is ignored
    @(negedge clk) left_smp = 18'h00005;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #2 check(silence_flag, 1'b1, "R7");
    end
    @(negedge clk) left_smp = '0;

    // R3: non-zero frame drops flag, run restarts
    cur_req = "R3";
    frame('0, 18'h00001, 1'b0);
    frames(ZR - 1, '0, '0, 1'b0);
    frame('1, '0, 1'b0);
    frames(ZR, '0, '0, 1'b0);

    // R4: mute trigger with non-zero data
    cur_req = "R4";
    frames(MT - 1, 18'h1F000, 18'h00010, 1'b1);
    frame(18'h1F000, 18'h00010, 1'b1);
    cur_req = "R8";
    frames(10, 18'h00003, '0, 1'b1);

    // R5: release between strobes drops the flag at once
    @(negedge clk) mute_req = 1'b0; mrun = 0;
    @(posedge clk);
    #2 check(silence_flag, 1'b0, "R5");
    cur_req = "R5";
    frames(3, 18'h00003, '0, 1'b0);

    // R6: OR coupling; zero run complete, mute toggles, flag stays
    cur_req = "R6";
    frames(ZR, '0, '0, 1'b0);
    frames(4, '0, '0, 1'b1);
    @(negedge clk) mute_req = 1'b0; mrun = 0;
    @(posedge clk);
    #2 check(silence_flag, 1'b1, "R6");

    // R5: new mute request counts from zero again
    cur_req = "R5";
    frames(MT - 1, 18'h00002, 18'h00002, 1'b1);
    frame(18'h00002, 18'h00002, 1'b1);
    frame(18'h00002, 18'h00002, 1'b0);

    // R1: reset mid-activity clears everything
    cur_req = "R1";
    frames(ZR, '0, '0, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #2 check(silence_flag, 1'b0, "R1");
    @(negedge clk) rst = 1'b0; zrun = 0; mrun = 0;
    frame('0, '0, 1'b0);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule